// File: doc/BRIEF.md
# Power Domain Bring-Up Sequencer

This block controls a switchable processor power domain from the always-on side of a chip. A host processor sends a single-cycle power-up command. The sequencer then steps through a fixed order. First it turns on the external supply switch. Next it waits a programmable number of cycles while the supply ramps. After that it drops the isolation wrapper on the domain boundary, enables the domain clock, and finally removes both the domain halt control and the domain reset control so that the processor inside can start booting.

A power-down command runs the same steps backwards. The domain can only be woken by a host command. An interrupt aimed at the sleeping domain has no effect on the sequencer. While isolation is active, every data bit leaving the domain is clamped to zero before it reaches always-on logic. A busy flag covers each sequence in progress, and an up flag reports a domain that is fully released.

Top module: `pdom_seq_top`

## Requirements
- R1: After synchronous reset the outputs are: switch off, isolation on, clock off, reset and halt both asserted, busy low, up low, clamped data zero.
- R2: A power-up command (up_req high for one cycle while the domain is off and idle) raises pwr_sw_en and busy in the next cycle. Isolation, clock and reset are unchanged in that cycle.
- R3: iso_en stays high for exactly N cycles counted from the first cycle with pwr_sw_en high. N is the ramp_cycles value sampled with the command, and a value of 0 counts as 1.
- R4: After the ramp wait, isolation is released. One cycle later dom_clk_en rises. One cycle after that, dom_rst and dom_halt both fall together.
- R5: up rises, and busy falls, exactly one cycle after dom_rst and dom_halt are released.
- R6: busy stays high in every cycle from the one after a command up to and including the last step of that sequence.
- R7: up_req and down_req are ignored while busy is high, and a sequence in flight keeps its timing.
- R8: irq_wake has no effect: an interrupt aimed at the off domain never turns the switch on.
- R9: A power-down command while up is high gives, in the following cycles, one step each: reset and halt asserted with up low, then clock off, then isolation on, then switch off with busy low.
- R10: dom_data_out is all zeros whenever iso_en is high and equals dom_data_in otherwise.
- R11: A change of ramp_cycles after the command has been taken does not change the ramp wait.
- R12: up_req while the domain is already up, and down_req while it is off, cause no change on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Power-up command pulse from the host |
| down_req | input | 1 | Power-down command pulse from the host |
| irq_wake | input | 1 | Interrupt aimed at the domain (never wakes it) |
| ramp_cycles | input | RAMP_W | Supply ramp wait in cycles, sampled at command |
| dom_data_in | input | DATA_W | Raw signals leaving the domain |
| pwr_sw_en | output | 1 | External power-switch enable |
| iso_en | output | 1 | Isolation wrapper active |
| dom_clk_en | output | 1 | Domain clock enable |
| dom_rst | output | 1 | Domain reset control, high = held in reset |
| dom_halt | output | 1 | Domain enable control, high = held halted |
| busy | output | 1 | Sequence in progress |
| up | output | 1 | Domain released and booting |
| dom_data_out | output | DATA_W | Domain signals after the isolation clamp |

## Verification
The bench measures the ramp window at its edges: a ramp value of 0, a value of 1, and larger values. A counter that is off by one would release isolation one cycle early or late, and a design that used zero as a count would hang or skip the wait. Commands that arrive mid-sequence, together with a change of the ramp value after start, check that a sequence already running can be neither restarted, cut short nor stretched. The reverse order on power-down, the clamp during both transitions, and an interrupt held for many cycles in the off state check for clock gating before reset, leaking domain data, and a wake-up that did not come from the host.

// File: rtl/pdom_seq_pkg.sv
package pdom_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_RAMP,
        ST_ISO_OFF,
        ST_CLK_ON,
        ST_RST_OFF,
        ST_ON,
        ST_PD_RST,
        ST_PD_CLK,
        ST_PD_ISO
    } seq_state_t;

    typedef struct packed {
        logic pwr;
        logic iso;
        logic clk;
        logic rst;
        logic halt;
        logic busy;
        logic up;
    } seq_ctrl_t;

    // Output pattern for each step of the sequence
    function automatic seq_ctrl_t ctrl_of(seq_state_t s);
        seq_ctrl_t c;
        c = '{pwr: 1'b0, iso: 1'b1, clk: 1'b0, rst: 1'b1, halt: 1'b1, busy: 1'b0, up: 1'b0};
        case (s)
            ST_RAMP:    c = '{pwr: 1'b1, iso: 1'b1, clk: 1'b0, rst: 1'b1, halt: 1'b1, busy: 1'b1, up: 1'b0};
            ST_ISO_OFF: c = '{pwr: 1'b1, iso: 1'b0, clk: 1'b0, rst: 1'b1, halt: 1'b1, busy: 1'b1, up: 1'b0};
            ST_CLK_ON:  c = '{pwr: 1'b1, iso: 1'b0, clk: 1'b1, rst: 1'b1, halt: 1'b1, busy: 1'b1, up: 1'b0};
            ST_RST_OFF: c = '{pwr: 1'b1, iso: 1'b0, clk: 1'b1, rst: 1'b0, halt: 1'b0, busy: 1'b1, up: 1'b0};
            ST_ON:      c = '{pwr: 1'b1, iso: 1'b0, clk: 1'b1, rst: 1'b0, halt: 1'b0, busy: 1'b0, up: 1'b1};
            ST_PD_RST:  c = '{pwr: 1'b1, iso: 1'b0, clk: 1'b1, rst: 1'b1, halt: 1'b1, busy: 1'b1, up: 1'b0};
            ST_PD_CLK:  c = '{pwr: 1'b1, iso: 1'b0, clk: 1'b0, rst: 1'b1, halt: 1'b1, busy: 1'b1, up: 1'b0};
            ST_PD_ISO:  c = '{pwr: 1'b1, iso: 1'b1, clk: 1'b0, rst: 1'b1, halt: 1'b1, busy: 1'b1, up: 1'b0};
            default:    ;
        endcase
        return c;
    endfunction

    // A zero ramp setting is raised to the one-cycle minimum
    function automatic logic [31:0] ramp_floor(logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/pdom_ramp_timer.sv
module pdom_ramp_timer #(
    parameter int RAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [RAMP_W-1:0] load_val,
    output logic              expire
);
    import pdom_seq_pkg::*;

    logic [RAMP_W-1:0] cnt_q;
    logic [31:0]       load_wide;
    logic [31:0]       floored;

    always_comb begin
        load_wide = 32'(load_val);
        floored   = ramp_floor(load_wide);
    end

    // Count down from the latched value; later edits of load_val are not seen
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= floored[RAMP_W-1:0];
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == RAMP_W'(1));

endmodule

// File: rtl/pdom_seq_fsm.sv
module pdom_seq_fsm (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     up_req,
    input  logic                     down_req,
    input  logic                     ramp_done,
    output logic                     ramp_load,
    output pdom_seq_pkg::seq_ctrl_t  ctrl
);
    import pdom_seq_pkg::*;

    seq_state_t state_q, state_d;
    seq_ctrl_t  ctrl_q;

    always_comb begin
        state_d   = state_q;
        ramp_load = 1'b0;
        case (state_q)
            ST_OFF: begin
                if (up_req) begin
                    state_d   = ST_RAMP;
                    ramp_load = 1'b1;
                end
            end
            ST_RAMP:    if (ramp_done) state_d = ST_ISO_OFF;
            ST_ISO_OFF: state_d = ST_CLK_ON;
            ST_CLK_ON:  state_d = ST_RST_OFF;
            ST_RST_OFF: state_d = ST_ON;
            ST_ON:      if (down_req) state_d = ST_PD_RST;
            ST_PD_RST:  state_d = ST_PD_CLK;
            ST_PD_CLK:  state_d = ST_PD_ISO;
            ST_PD_ISO:  state_d = ST_OFF;
            default:    state_d = ST_OFF;
        endcase
    end

    // Outputs leave from flops so the pins never glitch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            ctrl_q  <= ctrl_of(ST_OFF);
        end else begin
            state_q <= state_d;
            ctrl_q  <= ctrl_of(state_d);
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/pdom_iso_clamp.sv
module pdom_iso_clamp #(
    parameter int DATA_W = 8
) (
    input  logic              iso,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] safe
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign safe[i] = raw[i] & ~iso;
    end
endmodule

// File: rtl/pdom_seq_top.sv
module pdom_seq_top #(
    parameter int RAMP_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_req,
    input  logic              down_req,
    input  logic              irq_wake,
    input  logic [RAMP_W-1:0] ramp_cycles,
    input  logic [DATA_W-1:0] dom_data_in,
    output logic              pwr_sw_en,
    output logic              iso_en,
    output logic              dom_clk_en,
    output logic              dom_rst,
    output logic              dom_halt,
    output logic              busy,
    output logic              up,
    output logic [DATA_W-1:0] dom_data_out
);
    import pdom_seq_pkg::*;

    seq_ctrl_t ctrl;
    logic      ramp_load;
    logic      ramp_done;
    logic      irq_unused;

    // Interrupts for the sleeping domain are deliberately not a wake source
    assign irq_unused = irq_wake;

    pdom_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .up_req    (up_req),
        .down_req  (down_req),
        .ramp_done (ramp_done),
        .ramp_load (ramp_load),
        .ctrl      (ctrl)
    );

    pdom_ramp_timer #(.RAMP_W(RAMP_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ramp_load),
        .load_val (ramp_cycles),
        .expire   (ramp_done)
    );

    pdom_iso_clamp #(.DATA_W(DATA_W)) u_clamp (
        .iso  (ctrl.iso),
        .raw  (dom_data_in),
        .safe (dom_data_out)
    );

    assign pwr_sw_en  = ctrl.pwr;
    assign iso_en     = ctrl.iso;
    assign dom_clk_en = ctrl.clk;
    assign dom_rst    = ctrl.rst;
    assign dom_halt   = ctrl.halt;
    assign busy       = ctrl.busy;
    assign up         = ctrl.up;

endmodule

// File: rtl/pdom_seq_chk.sv
module pdom_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              up_req,
    input logic              pwr_sw_en,
    input logic              iso_en,
    input logic              dom_clk_en,
    input logic              dom_rst,
    input logic              dom_halt,
    input logic              busy,
    input logic              up,
    input logic [DATA_W-1:0] dom_data_out
);
    AST_SWITCH_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_sw_en) |-> $past(up_req)); // R8

    AST_ISO_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        !iso_en |-> pwr_sw_en); // R3

    AST_CLK_AFTER_ISO: assert property (@(posedge clk) disable iff (rst)
        dom_clk_en |-> !iso_en); // R4

    AST_REL_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
        (!dom_rst || !dom_halt) |-> dom_clk_en); // R4

    AST_UP_AFTER_REL: assert property (@(posedge clk) disable iff (rst)
        $rose(up) |-> ($past(!dom_rst) && $past(busy) && !busy)); // R5

    AST_CLK_GATE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(dom_clk_en) |-> (dom_rst && dom_halt)); // R9

    AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (rst)
        iso_en |-> (dom_data_out == '0)); // R10
endmodule

bind pdom_seq_top pdom_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .up_req       (up_req),
    .pwr_sw_en    (pwr_sw_en),
    .iso_en       (iso_en),
    .dom_clk_en   (dom_clk_en),
    .dom_rst      (dom_rst),
    .dom_halt     (dom_halt),
    .busy         (busy),
    .up           (up),
    .dom_data_out (dom_data_out)
);

// File: tb/pdom_seq_top_test.sv
`timescale 1ns/1ps
module pdom_seq_top_test;
    localparam int RAMP_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              up_req = 1'b0;
    logic              down_req = 1'b0;
    logic              irq_wake = 1'b0;
    logic [RAMP_W-1:0] ramp_cycles = '0;
    logic [DATA_W-1:0] dom_data_in = 8'hA5;
    logic              pwr_sw_en, iso_en, dom_clk_en, dom_rst, dom_halt, busy, up;
    logic [DATA_W-1:0] dom_data_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pdom_seq_top #(.RAMP_W(RAMP_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .up_req(up_req), .down_req(down_req),
        .irq_wake(irq_wake), .ramp_cycles(ramp_cycles), .dom_data_in(dom_data_in),
        .pwr_sw_en(pwr_sw_en), .iso_en(iso_en), .dom_clk_en(dom_clk_en),
        .dom_rst(dom_rst), .dom_halt(dom_halt), .busy(busy), .up(up),
        .dom_data_out(dom_data_out)
    );

    // pwr,iso,clk,rst,halt,busy,up packed for compact comparison
    function automatic logic [6:0] outs();
        return {pwr_sw_en, iso_en, dom_clk_en, dom_rst, dom_halt, busy, up};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    localparam logic [6:0] P_OFF   = 7'b0_1_0_1_1_0_0;
    localparam logic [6:0] P_RAMP  = 7'b1_1_0_1_1_1_0;
    localparam logic [6:0] P_ISO   = 7'b1_0_0_1_1_1_0;
    localparam logic [6:0] P_CLK   = 7'b1_0_1_1_1_1_0;
    localparam logic [6:0] P_REL   = 7'b1_0_1_0_0_1_0;
    localparam logic [6:0] P_ON    = 7'b1_0_1_0_0_0_1;
    localparam logic [6:0] P_PDRST = 7'b1_0_1_1_1_1_0;
    localparam logic [6:0] P_PDCLK = 7'b1_0_0_1_1_1_0;
    localparam logic [6:0] P_PDISO = 7'b1_1_0_1_1_1_0;

    // Power-up with ramp setting cfg; poke injects commands and a new ramp value mid-sequence
    task automatic run_up(input int cfg, input bit poke);
        int n;
        n = (cfg == 0) ? 1 : cfg;
        @(negedge clk);
        ramp_cycles = RAMP_W'(cfg);
        up_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        chk("R2 first step", 32'(outs()), 32'(P_RAMP));
        chk("R10 clamp during ramp", 32'(dom_data_out), 32'h0);
        if (poke) begin
            up_req = 1'b1; down_req = 1'b1; ramp_cycles = RAMP_W'(40);
        end
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            up_req = 1'b0; down_req = 1'b0;
            chk("R3 R6 R7 R11 ramp hold", 32'(outs()), 32'(P_RAMP));
        end
        @(negedge clk);
        up_req = 1'b0; down_req = 1'b0;
        chk("R3 R4 iso release", 32'(outs()), 32'(P_ISO));
        chk("R10 clamp pass", 32'(dom_data_out), 32'(dom_data_in));
        @(negedge clk);
        chk("R4 clock on", 32'(outs()), 32'(P_CLK));
        @(negedge clk);
        chk("R4 R6 reset release", 32'(outs()), 32'(P_REL));
        @(negedge clk);
        chk("R5 up", 32'(outs()), 32'(P_ON));
    endtask

    task automatic run_down(input bit poke);
        @(negedge clk);
        down_req = 1'b1;
        @(negedge clk);
        down_req = 1'b0;
        chk("R9 reset first", 32'(outs()), 32'(P_PDRST));
        if (poke) up_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        chk("R9 R7 clock gate", 32'(outs()), 32'(P_PDCLK));
        @(negedge clk);
        chk("R9 isolate", 32'(outs()), 32'(P_PDISO));
        chk("R10 clamp on power-down", 32'(dom_data_out), 32'h0);
        @(negedge clk);
        chk("R9 switch off", 32'(outs()), 32'(P_OFF));
    endtask

    task automatic test_reset();
        chk("R1 reset outputs", 32'(outs()), 32'(P_OFF));
        chk("R1 R10 reset clamp", 32'(dom_data_out), 32'h0);
    endtask

    task automatic test_irq_ignored();
        @(negedge clk);
        irq_wake = 1'b1;
        for (int k = 0; k < 20; k++) @(negedge clk);
        chk("R8 irq no wake", 32'(outs()), 32'(P_OFF));
        irq_wake = 1'b0;
    endtask

    task automatic test_stray_cmds();
        @(negedge clk);
        down_req = 1'b1;
        @(negedge clk);
        down_req = 1'b0;
        chk("R12 down while off", 32'(outs()), 32'(P_OFF));
    endtask

    task automatic test_up_while_on();
        @(negedge clk);
        up_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        chk("R12 up while on", 32'(outs()), 32'(P_ON));
        dom_data_in = 8'h3C;
        #0.5;
        chk("R10 pass when on", 32'(dom_data_out), 32'h3C);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_irq_ignored();
        test_stray_cmds();
        run_up(0, 1'b0);
        test_up_while_on();
        run_down(1'b0);
        run_up(1, 1'b0);
        run_down(1'b1);
        run_up(5, 1'b1);
        run_down(1'b0);
        run_up(12, 1'b1);
        run_down(1'b0);
        test_irq_ignored();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule